// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block takes every interrupt request a small processor can receive and decides, each cycle, which one it must serve next. Three kinds of source compete. The first kind is the fixed system exceptions: reset, an irregular-address fault, a debug trap and a non-maskable interrupt. The second is a watchdog overflow, which software steers to become either a reset or a non-maskable interrupt. The third is a set of maskable peripheral lines, and each of these carries its own enable bit and a 3-bit software level. The system exceptions always beat any maskable line. Among the maskable lines, the highest level wins, and when two levels are equal the lower slot number wins.

For the winning source the block presents a valid flag, the 5-bit vector number and the address from which the handler pointer is fetched. That address is a programmable table base plus four times the vector number. The debug trap is the exception to this rule: it always goes to one fixed address that is not in the table. The table base sits behind a 16-bit register bus as a low half and a high half, and it comes out of reset pointing at 0x8000.

The processor answers with an acknowledge. An acknowledge retires only the events that the block itself latched, namely a captured NMI edge and a watchdog reset. Level sources such as peripherals, the reset pin, faults and the debug trap stay visible until their owner drops them.

Top module: `irq_vector_arb`

## Requirements
- R1: After reset the table base is 0x0000_8000, so a bus read of 0x5328 returns 0x8000 and a read of 0x532A returns 0x0000. With all inputs idle, req_valid is 0.
- R2: For a winner other than debug, req_addr equals the lower 24 bits of (table base + 4 × req_vector).
- R3: A bus write with bus_sel=1 and bus_wr=1 loads base bits 15:0 at address 0x5328 and base bits 31:16 at address 0x532A, and reads at those addresses return the stored halves. An access to any other address changes nothing and reads 0.
- R4: The order of precedence, from highest to lowest, is reset (vector 0), irregular address (vector 1), debug, NMI (vector 2), and then the maskable sources. A reset is either ext_reset_req or a latched watchdog reset.
- R5: A debug winner drives req_debug=1, req_vector=0 and req_addr=0xFFFC00. For every other winner req_debug is 0.
- R6: Only slots 4–20, 22 and 23 can be taken as maskable sources. A request on slot 21, on slots 24–31 or on slots 0–3 of irq_req is never selected.
- R7: A maskable slot i is eligible only when irq_req[i]=1, src_en[i]=1 and global_ie=1, and its level src_level[3i+2:3i] is strictly greater than cpu_level. Level 0 is therefore never accepted.
- R8: Among the eligible slots, the one with the highest level wins. When levels are equal, the lower slot number wins.
- R9: A rising edge on nmi_in sets an NMI pending flag on that clock edge, and the flag shows from the next cycle. The flag clears only when req_ack=1 while NMI is the winner. An nmi_in that stays high does not set it again.
- R10: A wdt_event with wdt_sel_nmi=0 latches a pending reset, which shows as vector 0 from the next cycle until it is acknowledged. With wdt_sel_nmi=1 it sets the NMI pending flag instead.
- R11: req_ack has no effect on a maskable winner. That winner stays selected while its line is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_reset_req | input | 1 | Reset request level (vector 0) |
| addr_err_req | input | 1 | Irregular-address fault level (vector 1) |
| dbg_req | input | 1 | Debug trap level (fixed address) |
| nmi_in | input | 1 | Non-maskable interrupt, edge captured |
| wdt_event | input | 1 | Watchdog overflow pulse |
| wdt_sel_nmi | input | 1 | 1 routes the watchdog to NMI, 0 routes it to reset |
| irq_req | input | 32 | Maskable request lines, one per slot |
| src_en | input | 32 | Per-slot enable |
| src_level | input | 96 | Per-slot 3-bit level, slot i at bits 3i+2:3i |
| global_ie | input | 1 | Global maskable-interrupt enable |
| cpu_level | input | 3 | Current processor interrupt level |
| req_ack | input | 1 | Processor takes the presented request |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Register bus write |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data |
| req_valid | output | 1 | A request is presented |
| req_debug | output | 1 | The presented request is the debug trap |
| req_vector | output | 5 | Vector number of the winner |
| req_addr | output | 24 | Handler pointer fetch address |

## Verification
The bench aims at equal-level ties between slots that lie far apart, which a design that breaks ties the wrong way would hand to the higher slot number. It raises requests on reserved slot 21 and on slots above 23, which leaky masking would let through. It also probes a level equal to cpu_level and a level of 0, where a greater-or-equal comparison would wrongly accept the request. It peels the system exceptions away one at a time to expose a swapped priority order. It holds nmi_in high across an acknowledge to catch level-sensitive NMI capture, which would re-raise the interrupt forever. It sends the watchdog down both of its routes, and it acknowledges maskable winners to catch an acknowledge that wrongly drops a peripheral request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [2:0] {
      WIN_NONE    = 3'd0,
      WIN_RESET   = 3'd1,
      WIN_ADDRERR = 3'd2,
      WIN_DEBUG   = 3'd3,
      WIN_NMI     = 3'd4,
      WIN_MASK    = 3'd5
   } win_e;

   localparam int unsigned VEC_RESET   = 0;
   localparam int unsigned VEC_ADDRERR = 1;
   localparam int unsigned VEC_NMI     = 2;

endpackage

// File: rtl/irq_base_regs.sv
module irq_base_regs #(
   parameter int unsigned  BUS_W    = 16,
   parameter logic [31:0]  BASE_RST = 32'h0000_8000,
   parameter logic [15:0]  REG_LO   = 16'h5328,
   parameter logic [15:0]  REG_HI   = 16'h532A
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [15:0]        bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   output logic [2*BUS_W-1:0] base_o
);

   localparam int unsigned BASE_W = 2 * BUS_W;

   if (BUS_W != 16) begin : g_bad_bus
      $error("irq_base_regs: BUS_W must be 16");
   end
   if (REG_LO == REG_HI) begin : g_bad_map
      $error("irq_base_regs: register halves need distinct addresses");
   end

   logic [BUS_W-1:0] lo_q, hi_q;
   logic             hit_lo, hit_hi;

   assign hit_lo = bus_sel && (bus_addr == REG_LO);
   assign hit_hi = bus_sel && (bus_addr == REG_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= BASE_RST[BUS_W-1:0];
         hi_q <= BASE_RST[BASE_W-1:BUS_W];
      end else begin
         if (hit_lo && bus_wr) lo_q <= bus_wdata;
         if (hit_hi && bus_wr) hi_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_lo)      bus_rdata = lo_q;
      else if (hit_hi) bus_rdata = hi_q;
   end

   assign base_o = {hi_q, lo_q};

endmodule

// File: rtl/irq_sys_capture.sv
module irq_sys_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic wdt_event,
   input  logic wdt_sel_nmi,
   input  logic nmi_clr,
   input  logic rst_clr,
   output logic nmi_pend,
   output logic wdt_rst_pend
);

   logic nmi_prev_q;
   logic nmi_set, rst_set;

   assign nmi_set = (nmi_in && !nmi_prev_q) || (wdt_event && wdt_sel_nmi);
   assign rst_set = wdt_event && !wdt_sel_nmi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q   <= 1'b0;
         nmi_pend     <= 1'b0;
         wdt_rst_pend <= 1'b0;
      end else begin
         nmi_prev_q   <= nmi_in;
         nmi_pend     <= (nmi_pend && !nmi_clr) || nmi_set;
         wdt_rst_pend <= (wdt_rst_pend && !rst_clr) || rst_set;
      end
   end

endmodule

// File: rtl/irq_mask_pick.sv
module irq_mask_pick #(
   parameter int unsigned         NUM_VEC    = 32,
   parameter int unsigned         LVL_W      = 3,
   parameter logic [NUM_VEC-1:0]  MASK_SLOTS = 32'h00DF_FFF0,
   localparam int unsigned        VEC_W      = $clog2(NUM_VEC)
) (
   input  logic [NUM_VEC-1:0]       irq_req,
   input  logic [NUM_VEC-1:0]       src_en,
   input  logic [NUM_VEC*LVL_W-1:0] src_level,
   input  logic                     global_ie,
   input  logic [LVL_W-1:0]         cpu_level,
   output logic                     hit,
   output logic [VEC_W-1:0]         hit_vec,
   output logic [LVL_W-1:0]         hit_lvl
);

   localparam int unsigned NODES = 2 * NUM_VEC - 1;
   localparam int unsigned LEAF0 = NUM_VEC - 1;

   if ((NUM_VEC & (NUM_VEC - 1)) != 0 || NUM_VEC < 4) begin : g_bad_num
      $error("irq_mask_pick: NUM_VEC must be a power of two, at least 4");
   end

   logic             nd_v [NODES];
   logic [LVL_W-1:0] nd_l [NODES];
   logic [VEC_W-1:0] nd_i [NODES];

   for (genvar s = 0; s < NUM_VEC; s++) begin : g_leaf
      logic [LVL_W-1:0] lvl;
      assign lvl = src_level[s*LVL_W +: LVL_W];
      if (MASK_SLOTS[s]) begin : g_live
         assign nd_v[LEAF0+s] = irq_req[s] && src_en[s] && global_ie && (lvl > cpu_level);
      end else begin : g_dead
         assign nd_v[LEAF0+s] = 1'b0;
      end
      assign nd_l[LEAF0+s] = lvl;
      assign nd_i[LEAF0+s] = VEC_W'(s);
   end

   for (genvar k = 0; k < NUM_VEC - 1; k++) begin : g_node
      logic take_r;
      assign take_r = nd_v[2*k+2] && (!nd_v[2*k+1] || (nd_l[2*k+2] > nd_l[2*k+1]));
      assign nd_v[k] = nd_v[2*k+1] || nd_v[2*k+2];
      assign nd_l[k] = take_r ? nd_l[2*k+2] : nd_l[2*k+1];
      assign nd_i[k] = take_r ? nd_i[2*k+2] : nd_i[2*k+1];
   end

   assign hit     = nd_v[0];
   assign hit_vec = nd_i[0];
   assign hit_lvl = nd_l[0];

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
   parameter int unsigned         NUM_VEC    = 32,
   parameter int unsigned         LVL_W      = 3,
   parameter int unsigned         ADDR_W     = 24,
   parameter logic [31:0]         BASE_RST   = 32'h0000_8000,
   parameter logic [15:0]         REG_LO     = 16'h5328,
   parameter logic [15:0]         REG_HI     = 16'h532A,
   parameter logic [23:0]         DBG_ADDR   = 24'hFFFC00,
   parameter logic [NUM_VEC-1:0]  MASK_SLOTS = 32'h00DF_FFF0,
   localparam int unsigned        VEC_W      = $clog2(NUM_VEC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_reset_req,
   input  logic                     addr_err_req,
   input  logic                     dbg_req,
   input  logic                     nmi_in,
   input  logic                     wdt_event,
   input  logic                     wdt_sel_nmi,
   input  logic [NUM_VEC-1:0]       irq_req,
   input  logic [NUM_VEC-1:0]       src_en,
   input  logic [NUM_VEC*LVL_W-1:0] src_level,
   input  logic                     global_ie,
   input  logic [LVL_W-1:0]         cpu_level,
   input  logic                     req_ack,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [15:0]              bus_addr,
   input  logic [15:0]              bus_wdata,
   output logic [15:0]              bus_rdata,
   output logic                     req_valid,
   output logic                     req_debug,
   output logic [VEC_W-1:0]         req_vector,
   output logic [ADDR_W-1:0]        req_addr
);
   import irq_arb_pkg::*;

   if (ADDR_W < VEC_W + 2 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_vector_arb: ADDR_W out of range");
   end
   if (MASK_SLOTS[3:0] != 4'b0000) begin : g_bad_slots
      $error("irq_vector_arb: slots 0-3 are reserved for system exceptions");
   end

   logic [31:0]        base_q;
   logic               nmi_pend, wdt_rst_pend;
   logic               mk_hit;
   logic [VEC_W-1:0]   mk_vec;
   logic [LVL_W-1:0]   mk_lvl;
   win_e               win;
   logic               take;

   irq_base_regs #(
      .BUS_W(16), .BASE_RST(BASE_RST), .REG_LO(REG_LO), .REG_HI(REG_HI)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .base_o(base_q)
   );

   irq_sys_capture u_cap (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .wdt_event(wdt_event),
      .wdt_sel_nmi(wdt_sel_nmi),
      .nmi_clr(take && (win == WIN_NMI)),
      .rst_clr(take && (win == WIN_RESET)),
      .nmi_pend(nmi_pend), .wdt_rst_pend(wdt_rst_pend)
   );

   irq_mask_pick #(
      .NUM_VEC(NUM_VEC), .LVL_W(LVL_W), .MASK_SLOTS(MASK_SLOTS)
   ) u_pick (
      .irq_req(irq_req), .src_en(src_en), .src_level(src_level),
      .global_ie(global_ie), .cpu_level(cpu_level),
      .hit(mk_hit), .hit_vec(mk_vec), .hit_lvl(mk_lvl)
   );

   always_comb begin
      if (ext_reset_req || wdt_rst_pend) win = WIN_RESET;
      else if (addr_err_req)             win = WIN_ADDRERR;
      else if (dbg_req)                  win = WIN_DEBUG;
      else if (nmi_pend)                 win = WIN_NMI;
      else if (mk_hit)                   win = WIN_MASK;
      else                               win = WIN_NONE;
   end

   assign take = req_ack && (win != WIN_NONE);

   always_comb begin
      req_valid  = (win != WIN_NONE);
      req_debug  = (win == WIN_DEBUG);
      req_vector = '0;
      unique case (win)
         WIN_ADDRERR: req_vector = VEC_W'(VEC_ADDRERR);
         WIN_NMI:     req_vector = VEC_W'(VEC_NMI);
         WIN_MASK:    req_vector = mk_vec;
         default:     req_vector = VEC_W'(VEC_RESET);
      endcase
      if (win == WIN_DEBUG) req_addr = DBG_ADDR[ADDR_W-1:0];
      else                  req_addr = base_q[ADDR_W-1:0] + {{(ADDR_W-VEC_W-2){1'b0}}, req_vector, 2'b00};
   end

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
   parameter int unsigned         NUM_VEC    = 32,
   parameter int unsigned         LVL_W      = 3,
   parameter int unsigned         ADDR_W     = 24,
   parameter logic [15:0]         REG_LO     = 16'h5328,
   parameter logic [23:0]         DBG_ADDR   = 24'hFFFC00,
   parameter logic [NUM_VEC-1:0]  MASK_SLOTS = 32'h00DF_FFF0,
   localparam int unsigned        VEC_W      = $clog2(NUM_VEC)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ext_reset_req,
   input logic                     nmi_in,
   input logic                     wdt_event,
   input logic                     wdt_sel_nmi,
   input logic [NUM_VEC-1:0]       src_en,
   input logic [NUM_VEC*LVL_W-1:0] src_level,
   input logic                     global_ie,
   input logic [LVL_W-1:0]         cpu_level,
   input logic                     bus_sel,
   input logic                     bus_wr,
   input logic [15:0]              bus_addr,
   input logic [15:0]              bus_wdata,
   input logic [31:0]              base_q,
   input logic                     req_valid,
   input logic                     req_debug,
   input logic [VEC_W-1:0]         req_vector,
   input logic [ADDR_W-1:0]        req_addr
);

   p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_debug) |-> req_addr == ADDR_W'(base_q + {req_vector, 2'b00}));

   p_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == REG_LO) |=> base_q[15:0] == $past(bus_wdata));

   p_reset_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_reset_req |-> (req_valid && req_vector == '0 && !req_debug));

   p_debug_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_debug |-> (req_valid && req_addr == DBG_ADDR[ADDR_W-1:0]));

   p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_debug && req_vector > 2) |-> MASK_SLOTS[req_vector]);

   p_level_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_debug && req_vector > 2) |->
         (global_ie && src_en[req_vector] && src_level[req_vector*LVL_W +: LVL_W] > cpu_level));

   p_nmi_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_in) |=> req_valid);

   p_wdt_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_event && !wdt_sel_nmi) |=> (req_valid && req_vector == '0 && !req_debug));

endmodule

bind irq_vector_arb irq_arb_checker #(
   .NUM_VEC(NUM_VEC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .REG_LO(REG_LO),
   .DBG_ADDR(DBG_ADDR), .MASK_SLOTS(MASK_SLOTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_reset_req(ext_reset_req), .nmi_in(nmi_in),
   .wdt_event(wdt_event), .wdt_sel_nmi(wdt_sel_nmi), .src_en(src_en),
   .src_level(src_level), .global_ie(global_ie), .cpu_level(cpu_level),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .base_q(base_q), .req_valid(req_valid), .req_debug(req_debug),
   .req_vector(req_vector), .req_addr(req_addr)
);

// File: tb/irq_vector_arb_test.sv
module irq_vector_arb_test;

   localparam logic [31:0] SLOTS = 32'h00DF_FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_reset_req = 0, addr_err_req = 0, dbg_req = 0, nmi_in = 0;
   logic        wdt_event = 0, wdt_sel_nmi = 0, global_ie = 1, req_ack = 0;
   logic [31:0] irq_req = '0, src_en = '0;
   logic [95:0] src_level = '0;
   logic [2:0]  cpu_level = '0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        req_valid, req_debug;
   logic [4:0]  req_vector;
   logic [23:0] req_addr;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m_base;
   logic        m_nmi, m_prev, m_wrst;

   always #4 clk = ~clk;

   irq_vector_arb uut (
      .clk(clk), .rst_n(rst_n), .ext_reset_req(ext_reset_req),
      .addr_err_req(addr_err_req), .dbg_req(dbg_req), .nmi_in(nmi_in),
      .wdt_event(wdt_event), .wdt_sel_nmi(wdt_sel_nmi), .irq_req(irq_req),
      .src_en(src_en), .src_level(src_level), .global_ie(global_ie),
      .cpu_level(cpu_level), .req_ack(req_ack), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .req_valid(req_valid), .req_debug(req_debug),
      .req_vector(req_vector), .req_addr(req_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // highest eligible maskable slot, ties to lower index (R6 R7 R8)
   function automatic int pick_mask();
      int best = -1;
      int bl = 0;
      for (int i = 0; i < 32; i++) begin
         int l = int'(src_level[3*i +: 3]);
         if (SLOTS[i] && irq_req[i] && src_en[i] && global_ie && l > int'(cpu_level) && l > bl) begin
            best = i;
            bl = l;
         end
      end
      return best;
   endfunction

   // 0 none, 1 reset, 2 addr err, 3 debug, 4 nmi, 5 maskable (R4)
   function automatic int winner();
      if (ext_reset_req || m_wrst) return 1;
      if (addr_err_req)            return 2;
      if (dbg_req)                 return 3;
      if (m_nmi)                   return 4;
      if (pick_mask() >= 0)        return 5;
      return 0;
   endfunction

   task automatic step(input string tag);
      int w;
      logic [4:0] ev;
      logic [23:0] ea;
      @(negedge clk);
      w = winner();
      case (w)
         2: ev = 5'd1;
         4: ev = 5'd2;
         5: ev = 5'(pick_mask());
         default: ev = 5'd0;
      endcase
      ea = (w == 3) ? 24'hFFFC00 : 24'(m_base + {ev, 2'b00});
      chk({tag, " valid"}, {31'd0, req_valid}, {31'd0, (w != 0)});
      if (w != 0) begin
         chk({tag, " debug R5"}, {31'd0, req_debug}, {31'd0, (w == 3)});
         chk({tag, " vector"}, {27'd0, req_vector}, {27'd0, ev});
         chk({tag, " addr R2"}, {8'd0, req_addr}, {8'd0, ea});
      end
      if (bus_sel && !bus_wr) begin
         logic [15:0] er;
         er = (bus_addr == 16'h5328) ? m_base[15:0] :
              (bus_addr == 16'h532A) ? m_base[31:16] : 16'h0000;
         chk({tag, " rdata R3"}, {16'd0, bus_rdata}, {16'd0, er});
      end
      @(posedge clk);
      if (bus_sel && bus_wr && bus_addr == 16'h5328) m_base[15:0]  = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 16'h532A) m_base[31:16] = bus_wdata;
      m_nmi  = (m_nmi && !(req_ack && w == 4)) || (nmi_in && !m_prev) || (wdt_event && wdt_sel_nmi);
      m_wrst = (m_wrst && !(req_ack && w == 1)) || (wdt_event && !wdt_sel_nmi);
      m_prev = nmi_in;
      #1;
   endtask

   task automatic look(input string tag, input logic v, input logic [4:0] vec, input logic [23:0] a);
      #1;
      chk({tag, " valid"}, {31'd0, req_valid}, {31'd0, v});
      if (v) begin
         chk({tag, " vector"}, {27'd0, req_vector}, {27'd0, vec});
         chk({tag, " addr"}, {8'd0, req_addr}, {8'd0, a});
      end
   endtask

   task automatic set_src(input int s, input logic r, input logic e, input logic [2:0] l);
      irq_req[s] = r;
      src_en[s] = e;
      src_level[3*s +: 3] = l;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      step("R3 write");
      bus_sel = 0; bus_wr = 0;
   endtask

   initial begin
      #1_500_000;
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_base = 32'h0000_8000; m_nmi = 0; m_prev = 0; m_wrst = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      look("R1 idle", 1'b0, 5'd0, 24'd0);
      bus_sel = 1; bus_addr = 16'h5328; #1;
      chk("R1 base low", {16'd0, bus_rdata}, 32'h8000);
      bus_addr = 16'h532A; #1;
      chk("R1 base high", {16'd0, bus_rdata}, 32'h0000);
      bus_sel = 0;
      step("R1");

      // R3 base programming, R2 address
      bus_write(16'h5328, 16'h1234);
      bus_write(16'h532A, 16'h0012);
      bus_write(16'h5330, 16'hFFFF);
      bus_sel = 1; bus_addr = 16'h5328; #1;
      chk("R3 low kept", {16'd0, bus_rdata}, 32'h1234);
      bus_addr = 16'h5330; #1;
      chk("R3 other reads 0", {16'd0, bus_rdata}, 32'h0);
      bus_sel = 0;
      set_src(4, 1, 1, 3'd1);
      look("R2 slot4", 1'b1, 5'd4, 24'h121244);
      step("R2");

      // R8 tie and level order
      set_src(4, 0, 0, 0);
      set_src(9, 1, 1, 3'd3);
      set_src(5, 1, 1, 3'd3);
      look("R8 tie low wins", 1'b1, 5'd5, 24'h121248);
      step("R8");
      set_src(9, 1, 1, 3'd4);
      look("R8 higher level", 1'b1, 5'd9, 24'h121258);
      step("R8");
      set_src(9, 0, 0, 0); set_src(5, 0, 0, 0);

      // R6 reserved slots
      set_src(21, 1, 1, 3'd7); set_src(30, 1, 1, 3'd7); set_src(3, 1, 1, 3'd7);
      look("R6 reserved ignored", 1'b0, 5'd0, 24'd0);
      step("R6");
      set_src(21, 0, 0, 0); set_src(30, 0, 0, 0); set_src(3, 0, 0, 0);

      // R7 gating
      set_src(6, 1, 1, 3'd2); cpu_level = 3'd2;
      look("R7 equal level refused", 1'b0, 5'd0, 24'd0);
      step("R7");
      cpu_level = 3'd1;
      look("R7 above level", 1'b1, 5'd6, 24'h12124C);
      step("R7");
      global_ie = 0;
      look("R7 gie off", 1'b0, 5'd0, 24'd0);
      step("R7");
      global_ie = 1; cpu_level = 0; set_src(6, 1, 1, 3'd0);
      look("R7 level zero", 1'b0, 5'd0, 24'd0);
      step("R7");
      set_src(6, 1, 0, 3'd5);
      look("R7 disabled", 1'b0, 5'd0, 24'd0);
      step("R7");
      set_src(6, 1, 1, 3'd5);

      // R4 priority peel, R9 nmi
      nmi_in = 1;
      step("R9 edge");
      ext_reset_req = 1; addr_err_req = 1; dbg_req = 1;
      look("R4 reset first", 1'b1, 5'd0, 24'h121234);
      step("R4");
      ext_reset_req = 0;
      look("R4 addr err", 1'b1, 5'd1, 24'h121238);
      step("R4");
      addr_err_req = 0;
      #1;
      chk("R5 debug flag", {31'd0, req_debug}, 32'd1);
      look("R5 debug addr", 1'b1, 5'd0, 24'hFFFC00);
      step("R5");
      dbg_req = 0;
      look("R4 nmi over mask", 1'b1, 5'd2, 24'h12123C);
      req_ack = 1;
      step("R9 ack");
      req_ack = 0;
      look("R9 held high no refire", 1'b1, 5'd6, 24'h12124C);
      step("R9");
      nmi_in = 0;
      step("R9");

      // R11 ack on maskable
      req_ack = 1;
      step("R11");
      req_ack = 0;
      look("R11 mask kept", 1'b1, 5'd6, 24'h12124C);
      set_src(6, 0, 0, 0);

      // R10 watchdog routes
      wdt_sel_nmi = 0; wdt_event = 1;
      step("R10");
      wdt_event = 0;
      look("R10 to reset", 1'b1, 5'd0, 24'h121234);
      step("R10");
      look("R10 held", 1'b1, 5'd0, 24'h121234);
      req_ack = 1;
      step("R10 ack");
      req_ack = 0;
      look("R10 cleared", 1'b0, 5'd0, 24'd0);
      wdt_sel_nmi = 1; wdt_event = 1;
      step("R10");
      wdt_event = 0;
      look("R10 to nmi", 1'b1, 5'd2, 24'h12123C);
      req_ack = 1;
      step("R10");
      req_ack = 0;

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         irq_req   = $urandom();
         src_en    = $urandom();
         src_level = {$urandom(), $urandom(), $urandom()};
         cpu_level = 3'($urandom_range(0, 7));
         global_ie = ($urandom_range(0, 9) != 0);
         ext_reset_req = ($urandom_range(0, 39) == 0);
         addr_err_req  = ($urandom_range(0, 29) == 0);
         dbg_req       = ($urandom_range(0, 29) == 0);
         nmi_in        = ($urandom_range(0, 3) == 0) ? ~nmi_in : nmi_in;
         wdt_event     = ($urandom_range(0, 49) == 0);
         wdt_sel_nmi   = 1'($urandom());
         req_ack       = 1'($urandom());
         bus_sel       = ($urandom_range(0, 7) == 0);
         bus_wr        = 1'($urandom());
         case ($urandom_range(0, 2))
            0: bus_addr = 16'h5328;
            1: bus_addr = 16'h532A;
            default: bus_addr = 16'($urandom());
         endcase
         bus_wdata = 16'($urandom());
         step("R2/R4/R6/R7/R8 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule